// File: doc/BRIEF.md
# Shared Weight-Set Buffer with Column Arbitration

This block sits between a single-port weight memory and a row of compute columns. Each column advances through activation bricks at its own pace. When a column moves on, it asks for the weight set with the next index. A weight set is one full group of weights for all filters.

The block keeps recently fetched sets in a small bank of registers. Each register carries a counter of the columns that have not yet taken its set. A set is fetched from memory once and stays buffered until every column has copied it. Total memory traffic therefore matches a fully lockstep array, while columns are still free to drift apart by as many sets as the bank can hold.

A request is granted in the same cycle it is seen. It is served from a register when the set is buffered. Otherwise it is served straight from the memory port, and the set is loaded into a free register at the same time. A column whose request cannot be served keeps its request raised and waits.

Top module: `wset_share_buf`

## Requirements
- R1: While reset is held, and in the first cycle after it with no requests, no column is granted, no memory read is issued, and all data outputs are zero. All buffer registers start empty.
- R2: At most one memory read is issued per cycle. A read is issued only in a cycle where at least one column is granted from it.
- R3: A requesting column whose set index matches a buffered set is granted in that cycle, and every such column is served together. A column that does not request is never granted.
- R4: When the winning missing column is served, `mem_rd_addr` equals its set index, `mem_rd_en` is 1, and the column is granted in the same cycle with `mem_rd_data` as its data.
- R5: Among columns that request a set not in the buffer, the lowest column index wins the read. Other missing columns that ask for the same index are granted with it. Missing columns that ask for a different index are not granted that cycle.
- R6: A buffered set is kept until all NCOL columns have taken it and is then released. When columns request sets in increasing index order, each set is read from memory exactly once and in index order. A request for a released set triggers a new read.
- R7: When no register is free, a request for an unbuffered set is not granted and no memory read is issued.
- R8: The data output slice of a granted column (SET_W bits, slice c at bits c*SET_W upward) carries the contents of the requested set. The slice of an ungranted column is all zeros.
- R9: A newly loaded register starts with NCOL minus the number of columns granted in the read cycle. If that number is zero, no register is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_req | input | NCOL | Per-column request for its next weight set |
| col_idx | input | NCOL*IDX_W | Per-column requested set index, column c at bits c*IDX_W upward |
| col_gnt | output | NCOL | Per-column grant, same cycle as the request |
| col_data | output | NCOL*SET_W | Per-column granted set contents, zero when not granted |
| mem_rd_en | output | 1 | Weight memory read strobe |
| mem_rd_addr | output | IDX_W | Set index being read |
| mem_rd_data | input | SET_W | Set contents returned in the same cycle as the read |

## Verification
A wrong copy counter is the most likely fault. If a register is released too early, a lagging column misses and causes a second read of the same index. This shows as `mem_rd_addr` jumping backward, in the very cycle the lagging column asks. If a register is held too long, the bank fills up. Columns running ahead then stall, so expected grants are missing within a few cycles. A wrong arbitration or match decision shows as a grant mismatch in the same cycle, and stale register contents show as a wrong data slice on the granted column.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    localparam int unsigned WSB_DEF_COLS  = 4;
    localparam int unsigned WSB_DEF_REGS  = 2;
    localparam int unsigned WSB_DEF_IDX_W = 8;
    localparam int unsigned WSB_DEF_SET_W = 32;

    // bits needed to index n things (at least one)
    function automatic int unsigned wsb_sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // bits needed to hold the value n itself
    function automatic int unsigned wsb_cnt_bits(input int unsigned n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/wsb_prio_pick.sv
module wsb_prio_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned PW = 2
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [PW-1:0] pos
);

    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end

endmodule

// File: rtl/wsb_hit_match.sv
module wsb_hit_match #(
    parameter int unsigned NCOL  = 4,
    parameter int unsigned NREG  = 2,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned REG_W = 1
) (
    input  logic [NCOL*IDX_W-1:0] col_idx,
    input  logic [NREG-1:0]       reg_vld,
    input  logic [NREG*IDX_W-1:0] reg_idx,
    output logic [NCOL-1:0]       hit,
    output logic [NCOL*REG_W-1:0] sel
);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [NREG-1:0] eq;
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            assign eq[r] = reg_vld[r] &&
                           (reg_idx[r*IDX_W +: IDX_W] == col_idx[c*IDX_W +: IDX_W]);
        end
        wsb_prio_pick #(.N(NREG), .PW(REG_W)) u_pick (
            .cand  (eq),
            .found (hit[c]),
            .pos   (sel[c*REG_W +: REG_W])
        );
    end

endmodule

// File: rtl/wset_share_buf.sv
module wset_share_buf
    import wsb_pkg::*;
#(
    parameter int unsigned NCOL  = WSB_DEF_COLS,
    parameter int unsigned NREG  = WSB_DEF_REGS,
    parameter int unsigned IDX_W = WSB_DEF_IDX_W,
    parameter int unsigned SET_W = WSB_DEF_SET_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCOL-1:0]       col_req,
    input  logic [NCOL*IDX_W-1:0] col_idx,
    output logic [NCOL-1:0]       col_gnt,
    output logic [NCOL*SET_W-1:0] col_data,
    output logic                  mem_rd_en,
    output logic [IDX_W-1:0]      mem_rd_addr,
    input  logic [SET_W-1:0]      mem_rd_data
);

    localparam int unsigned REG_W = wsb_sel_bits(NREG);
    localparam int unsigned COL_W = wsb_sel_bits(NCOL);
    localparam int unsigned CNT_W = wsb_cnt_bits(NCOL);

    typedef struct packed {
        logic [NREG-1:0]                  vld;
        logic [NREG-1:0][IDX_W-1:0]       idx;
        logic [NREG-1:0][CNT_W-1:0]       cnt;
        logic [NREG-1:0][SET_W-1:0]       data;
    } bank_t;

    bank_t st_q, st_d;

    // buffer lookup
    logic [NCOL-1:0]       col_hit;
    logic [NCOL*REG_W-1:0] col_sel;
    logic [NREG*IDX_W-1:0] reg_idx_flat;

    assign reg_idx_flat = st_q.idx;

    wsb_hit_match #(
        .NCOL(NCOL), .NREG(NREG), .IDX_W(IDX_W), .REG_W(REG_W)
    ) u_match (
        .col_idx (col_idx),
        .reg_vld (st_q.vld),
        .reg_idx (reg_idx_flat),
        .hit     (col_hit),
        .sel     (col_sel)
    );

    // miss arbitration and free-register choice
    logic [NCOL-1:0]  miss_req;
    logic             win_vld;
    logic [COL_W-1:0] win_col;
    logic             free_vld;
    logic [REG_W-1:0] free_reg;

    assign miss_req = col_req & ~col_hit;

    wsb_prio_pick #(.N(NCOL), .PW(COL_W)) u_arb (
        .cand  (miss_req),
        .found (win_vld),
        .pos   (win_col)
    );

    wsb_prio_pick #(.N(NREG), .PW(REG_W)) u_free (
        .cand  (~st_q.vld),
        .found (free_vld),
        .pos   (free_reg)
    );

    logic [IDX_W-1:0] win_idx;
    logic             rd_go;
    logic [NCOL-1:0]  miss_gnt;
    logic [NCOL-1:0]  hit_gnt;
    logic [CNT_W-1:0] miss_n;

    always_comb begin
        win_idx = col_idx[win_col*IDX_W +: IDX_W];
        rd_go   = win_vld && free_vld;
        hit_gnt = col_req & col_hit;
        miss_n  = '0;
        for (int c = 0; c < NCOL; c++) begin
            miss_gnt[c] = rd_go && miss_req[c] &&
                          (col_idx[c*IDX_W +: IDX_W] == win_idx);
            if (miss_gnt[c]) begin
                miss_n = miss_n + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        col_gnt     = hit_gnt | miss_gnt;
        mem_rd_en   = rd_go;
        mem_rd_addr = rd_go ? win_idx : '0;
        col_data    = '0;
        for (int c = 0; c < NCOL; c++) begin
            if (hit_gnt[c]) begin
                col_data[c*SET_W +: SET_W] = st_q.data[col_sel[c*REG_W +: REG_W]];
            end else if (miss_gnt[c]) begin
                col_data[c*SET_W +: SET_W] = mem_rd_data;
            end
        end
    end

    // next state
    logic [NREG-1:0][CNT_W-1:0] dec;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREG; r++) begin
            dec[r] = '0;
            for (int c = 0; c < NCOL; c++) begin
                if (hit_gnt[c] && (col_sel[c*REG_W +: REG_W] == REG_W'(r))) begin
                    dec[r] = dec[r] + CNT_W'(1);
                end
            end
            if (st_q.vld[r]) begin
                st_d.cnt[r] = st_q.cnt[r] - dec[r];
                if (st_d.cnt[r] == '0) begin
                    st_d.vld[r] = 1'b0;
                end
            end
        end
        if (rd_go && (miss_n != CNT_W'(NCOL))) begin
            st_d.vld[free_reg]  = 1'b1;
            st_d.idx[free_reg]  = win_idx;
            st_d.cnt[free_reg]  = CNT_W'(NCOL) - miss_n;
            st_d.data[free_reg] = mem_rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    rd_has_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (col_gnt != '0));

    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_gnt & ~col_req) == '0);

    for (genvar r = 0; r < NREG; r++) begin : g_reg_chk
        // R9
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vld[r] |-> (st_q.cnt[r] <= CNT_W'(NCOL)) && (st_q.cnt[r] != '0));

        // R6
        held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.vld[r] && $past(st_q.vld[r])) |->
                ($stable(st_q.idx[r]) && $stable(st_q.data[r])));

        // R6
        cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.vld[r] && $past(st_q.vld[r])) |-> (st_q.cnt[r] <= $past(st_q.cnt[r])));

        for (genvar s = r + 1; s < NREG; s++) begin : g_pair
            // R6
            no_dup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[r] && st_q.vld[s]) |-> (st_q.idx[r] != st_q.idx[s]));
        end
    end

endmodule

// File: tb/wset_share_buf_tb.sv
module wset_share_buf_tb_top;

    localparam int NCOL  = 4;
    localparam int NREG  = 2;
    localparam int IDX_W = 8;
    localparam int SET_W = 32;
    localparam int NSETS = 40;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NCOL-1:0]       col_req = '0;
    logic [NCOL*IDX_W-1:0] col_idx = '0;
    logic [NCOL-1:0]       col_gnt;
    logic [NCOL*SET_W-1:0] col_data;
    logic                  mem_rd_en;
    logic [IDX_W-1:0]      mem_rd_addr;
    logic [SET_W-1:0]      mem_rd_data;

    always #2 clk = ~clk;

    function automatic logic [SET_W-1:0] fdat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b, b ^ 8'hA5, ~b, b + 8'd7};
    endfunction

    assign mem_rd_data = fdat(int'(mem_rd_addr));

    wset_share_buf #(
        .NCOL(NCOL), .NREG(NREG), .IDX_W(IDX_W), .SET_W(SET_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .col_req(col_req), .col_idx(col_idx),
        .col_gnt(col_gnt), .col_data(col_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    int checks = 0;
    int fails = 0;
    bit wd_fired = 0;

    int nxt [NCOL];
    int wt  [NCOL];
    bit rq  [NCOL];
    bit m_vld [NREG];
    int m_idx [NREG];
    int m_cnt [NREG];
    int reads;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int waitfn(input int c, input int k, input int pat);
        return (c * 7 + k * (pat * 3 + 1) + pat) % (pat * 2 + 1);
    endfunction

    task automatic do_reset();
        rst_n   = 1'b0;
        col_req = '0;
        col_idx = '0;
        for (int r = 0; r < NREG; r++) begin
            m_vld[r] = 0; m_idx[r] = 0; m_cnt[r] = 0;
        end
        reads = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(col_gnt == '0 && !mem_rd_en && col_data == '0, "R1 in reset", longint'(col_gnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(col_gnt == '0, "R1 gnt", longint'(col_gnt), 0);
        chk(!mem_rd_en, "R1 rd", longint'(mem_rd_en), 0);
        chk(col_data == '0, "R1 data", 0, 0);
    endtask

    task automatic step(input int pat);
        bit h [NCOL];
        int hr [NCOL];
        bit eg [NCOL];
        int win;
        int fr;
        bit rd;
        int ng;
        int widx;
        string lbl;
        @(negedge clk);
        for (int c = 0; c < NCOL; c++) begin
            if (!rq[c] && nxt[c] < NSETS) begin
                if (wt[c] == 0) rq[c] = 1;
                else wt[c]--;
            end
            col_req[c] = rq[c];
            col_idx[c*IDX_W +: IDX_W] = IDX_W'(nxt[c]);
        end
        #1;
        win = -1;
        fr = -1;
        for (int c = 0; c < NCOL; c++) begin
            h[c] = 0; hr[c] = 0;
            for (int r = 0; r < NREG; r++) begin
                if (m_vld[r] && m_idx[r] == nxt[c]) begin
                    h[c] = 1; hr[c] = r;
                end
            end
            if (rq[c] && !h[c] && win < 0) win = c;
        end
        for (int r = 0; r < NREG; r++) begin
            if (!m_vld[r] && fr < 0) fr = r;
        end
        rd = (win >= 0) && (fr >= 0);
        widx = rd ? nxt[win] : 0;
        ng = 0;
        for (int c = 0; c < NCOL; c++) begin
            eg[c] = rq[c] && (h[c] || (rd && nxt[c] == widx));
            if (eg[c] && !h[c]) ng++;
        end
        chk(mem_rd_en == rd, "R2 read strobe", longint'(mem_rd_en), longint'(rd));
        if (rd && mem_rd_en) begin
            chk(int'(mem_rd_addr) == reads, "R6 read order", longint'(mem_rd_addr), longint'(reads));
            chk(int'(mem_rd_addr) == widx, "R4 read addr", longint'(mem_rd_addr), longint'(widx));
        end
        for (int c = 0; c < NCOL; c++) begin
            if (!rq[c] || h[c]) lbl = "R3 grant";
            else if (eg[c]) lbl = "R4 grant";
            else if (fr < 0) lbl = "R7 stall";
            else lbl = "R5 arbitration";
            chk(col_gnt[c] == eg[c], lbl, longint'(col_gnt[c]), longint'(eg[c]));
            if (eg[c])
                chk(col_data[c*SET_W +: SET_W] == fdat(nxt[c]), "R8 data",
                    longint'(col_data[c*SET_W +: SET_W]), longint'(fdat(nxt[c])));
            else
                chk(col_data[c*SET_W +: SET_W] == '0, "R8 zero",
                    longint'(col_data[c*SET_W +: SET_W]), 0);
        end
        for (int c = 0; c < NCOL; c++) begin
            if (eg[c] && h[c]) m_cnt[hr[c]]--;
        end
        for (int r = 0; r < NREG; r++) begin
            if (m_vld[r] && m_cnt[r] == 0) m_vld[r] = 0;
        end
        if (rd) begin
            reads++;
            if (NCOL - ng > 0) begin
                m_vld[fr] = 1; m_idx[fr] = widx; m_cnt[fr] = NCOL - ng;
            end
        end
        for (int c = 0; c < NCOL; c++) begin
            if (eg[c]) begin
                nxt[c]++;
                rq[c] = 0;
                wt[c] = waitfn(c, nxt[c], pat);
            end
        end
    endtask

    task automatic run_pattern(input int pat);
        bit done;
        do_reset();
        for (int c = 0; c < NCOL; c++) begin
            nxt[c] = 0; rq[c] = 0; wt[c] = waitfn(c, 0, pat);
        end
        done = 0;
        for (int n = 0; n < 3000 && !done; n++) begin
            step(pat);
            done = 1;
            for (int c = 0; c < NCOL; c++) if (nxt[c] < NSETS) done = 0;
        end
        chk(reads == NSETS, "R6 one read per set", longint'(reads), longint'(NSETS));
        // released set is fetched again
        @(negedge clk);
        col_req = 4'b0001;
        col_idx[0 +: IDX_W] = IDX_W'(NSETS - 1);
        #1;
        chk(mem_rd_en && int'(mem_rd_addr) == NSETS - 1, "R6 re-read after release",
            longint'(mem_rd_addr), longint'(NSETS - 1));
        chk(col_gnt == 4'b0001, "R6 re-read grant", longint'(col_gnt), 1);
    endtask

    task automatic directed_counter();
        do_reset();
        // columns 0 and 1 take set 5 from memory together
        @(negedge clk);
        col_req = 4'b0011;
        for (int c = 0; c < NCOL; c++) col_idx[c*IDX_W +: IDX_W] = 8'd5;
        #1;
        chk(col_gnt == 4'b0011 && mem_rd_en, "R5 shared miss", longint'(col_gnt), 3);
        chk(col_data[SET_W +: SET_W] == fdat(5), "R8 shared data",
            longint'(col_data[SET_W +: SET_W]), longint'(fdat(5)));
        // columns 2 and 3 hit, no read
        @(negedge clk);
        col_req = 4'b1100;
        #1;
        chk(col_gnt == 4'b1100 && !mem_rd_en, "R9 hit from counter 2", longint'(col_gnt), 12);
        chk(col_data[3*SET_W +: SET_W] == fdat(5), "R3 hit data",
            longint'(col_data[3*SET_W +: SET_W]), longint'(fdat(5)));
        // counter reached zero: set must be fetched again
        @(negedge clk);
        col_req = 4'b0001;
        #1;
        chk(mem_rd_en && mem_rd_addr == 8'd5, "R9 release at zero", longint'(mem_rd_en), 1);
        // fill both registers then stall a third set (R7)
        do_reset();
        @(negedge clk);
        col_req = 4'b0001; col_idx[0 +: IDX_W] = 8'd1;
        @(negedge clk);
        col_idx[0 +: IDX_W] = 8'd2;
        @(negedge clk);
        col_req = 4'b0110;
        col_idx[1*IDX_W +: IDX_W] = 8'd3;
        col_idx[2*IDX_W +: IDX_W] = 8'd4;
        #1;
        chk(col_gnt == '0 && !mem_rd_en, "R7 bank full", longint'(col_gnt), 0);
        col_idx[1*IDX_W +: IDX_W] = 8'd2;
        #1;
        chk(col_gnt == 4'b0010 && !mem_rd_en, "R7 hit while full", longint'(col_gnt), 2);
        @(negedge clk);
        col_req = '0;
    endtask

    initial begin
        fork
            begin
                directed_counter();
                for (int p = 0; p < 4; p++) run_pattern(p);
            end
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule